// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

The block moves data between one narrow port A and a wide port split into two halves, B1 and B2, all stored on the rising clock edge. In the A-to-B direction it gathers two successive narrow words and presents them together on the two halves. The first word passes through two register stages toward B1. The second word passes through a single register toward B2. Both halves update on the same edge. In the B-to-A direction a select input picks which wide half is registered onto A.

The transfer direction is itself sampled by the clock. A direction change therefore takes effect only at an edge. An active-low output enable gates the drive flags of both sides without waiting for the clock. Three-state pins are modelled as a data vector plus an enable flag per side.

Top module: `bus_exchanger`

## Requirements
- R1: A synchronous active-high reset clears every data register and the direction register to 0. After reset, with the output enable low, `a_oe` is 1 and `b_oe` is 0, and all data outputs read 0.
- R2: `dir_in` is registered. Changing it alters neither drive flag until the next rising edge.
- R3: While `oe_n` is 1, `a_oe` and `b_oe` are both 0 at once, without waiting for a clock edge.
- R4: While `oe_n` is 0, a registered direction of 1 gives `b_oe`=1 and `a_oe`=0. A registered direction of 0 gives `a_oe`=1 and `b_oe`=0.
- R5: With registered direction 1, an edge with `sel`=0 captures `a_in` into the B1 staging register and leaves `b1_out` and `b2_out` unchanged.
- R6: With registered direction 1, an edge with `sel`=1 loads `b1_out` from the staging register and `b2_out` from `a_in` on that same edge.
- R7: A word captured with `sel`=0 reaches `b1_out` on the second of two edges, the later one with `sel`=1. It is paired with the word present on `a_in` at that later edge.
- R8: With registered direction 0, each edge loads `a_out` with `b1_in` when `sel`=0, or with `b2_in` when `sel`=1.
- R9: Registers of the inactive direction hold. `a_out` holds while the registered direction is 1. `b1_out`, `b2_out` and the staging register hold while it is 0.
- R10: Repeated `sel`=1 edges with no `sel`=0 edge between them leave `b1_out` at the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all storage on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable, not clocked |
| dir_in | input | 1 | Direction request, 1 = A-to-B, 0 = B-to-A, sampled on the clock |
| sel | input | 1 | Half select / load steering |
| a_in | input | W | Narrow port A data in |
| b1_in | input | W | Wide half B1 data in |
| b2_in | input | W | Wide half B2 data in |
| a_out | output | W | Registered data toward port A |
| a_oe | output | 1 | Port A drive enable |
| b1_out | output | W | Registered data toward half B1 |
| b2_out | output | W | Registered data toward half B2 |
| b_oe | output | 1 | Port B drive enable |

## Verification
Two things can fall in the same cycle. One is a direction change, which takes effect at the edge. The other is a data load, which on that edge still follows the old registered direction. The bench flips `dir_in` with known B data present. It expects `a_out` to load from the selected half on the very edge that turns the drive flags over, with the B registers untouched. The same overlap is checked the other way when returning to A-to-B. A second overlap is the B1 and B2 updates on one `sel`=1 edge. This is swept over every pair of narrow words in a 4-bit configuration.

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir_in,
  input  logic         sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b1_out,
  output logic [W-1:0] b2_out,
  output logic         b_oe
);

  logic         dir_q;
  logic [W-1:0] stage_q;
  logic [W-1:0] b1_q;
  logic [W-1:0] b2_q;
  logic [W-1:0] a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= 1'b0;
      stage_q <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      a_q     <= '0;
    end else begin
      dir_q <= dir_in;
      if (dir_q) begin
        if (sel) begin
          b1_q <= stage_q;
          b2_q <= a_in;
        end else begin
          stage_q <= a_in;
        end
      end else begin
        a_q <= sel ? b2_in : b1_in;
      end
    end
  end

  assign a_out  = a_q;
  assign b1_out = b1_q;
  assign b2_out = b2_q;
  assign a_oe   = ~oe_n & ~dir_q;
  assign b_oe   = ~oe_n &  dir_q;

endmodule

module bus_exchanger_checks #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         oe_n,
  input logic         dir_in,
  input logic         sel,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b2_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b1_out,
  input logic         a_oe,
  input logic         b_oe
);

  logic ran;
  always_ff @(posedge clk) ran <= ~rst;

  assert_oe_off_R3: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe));

  assert_one_side_R4: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));

  assert_dir_clocked_R2: assert property (@(posedge clk) disable iff (rst)
    (ran && !oe_n) |-> (b_oe == $past(dir_in)));

  assert_a_load_R8: assert property (@(posedge clk) disable iff (rst)
    (ran && !$past(b_oe || a_oe ? b_oe : 1'b0) && !$past(oe_n) && $past(a_oe))
      |-> (a_out == ($past(sel) ? $past(b2_in) : $past(b1_in))));

  assert_a_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ran && !$past(oe_n) && $past(b_oe)) |-> (a_out == $past(a_out)));

  assert_b1_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ran && !$past(oe_n) && $past(b_oe) && $past(sel) && $past(ran) &&
     $past(b_oe, 2) && !$past(oe_n, 2) && $past(sel, 2))
      |-> (b1_out == $past(b1_out)));

endmodule

bind bus_exchanger bus_exchanger_checks #(.W(W)) u_checks (
  .clk(clk), .rst(rst), .oe_n(oe_n), .dir_in(dir_in), .sel(sel),
  .b1_in(b1_in), .b2_in(b2_in), .a_out(a_out), .b1_out(b1_out),
  .a_oe(a_oe), .b_oe(b_oe)
);

// File: tb/bus_exchanger_test.sv
module bus_exchanger_test;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst, oe_n, dir_in, sel;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_oe, b_oe;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [W-1:0] e_stage, e_b1, e_b2, e_a;

  always #10 clk = ~clk;

  bus_exchanger #(.W(W)) uut (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir_in(dir_in), .sel(sel),
    .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
    .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b2_out(b2_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; oe_n = 1'b0; dir_in = 1'b1; sel = 1'b0;
    a_in = '1; b1_in = '1; b2_in = '1;
    @(negedge clk);
    tick();
    // R1: reset state, direction cleared to 0 despite dir_in=1
    chk("R1 a_out", a_out, 0);
    chk("R1 b1_out", b1_out, 0);
    chk("R1 b2_out", b2_out, 0);
    chk("R1 a_oe", a_oe, 1);
    chk("R1 b_oe", b_oe, 0);
    rst = 1'b0; dir_in = 1'b0;
    e_stage = '0; e_b1 = '0; e_b2 = '0; e_a = '0;

    // R3: output enable acts without a clock
    #2 oe_n = 1'b1; #1;
    chk("R3 a_oe", a_oe, 0);
    chk("R3 b_oe", b_oe, 0);
    oe_n = 1'b0; #1;
    chk("R4 a_oe", a_oe, 1);

    // R8 / R9: exhaustive B-to-A sweep, B side must hold
    for (int x = 0; x < N; x++)
      for (int y = 0; y < N; y++)
        for (int s = 0; s < 2; s++) begin
          b1_in = W'(x); b2_in = W'(y); sel = s[0]; a_in = W'(x ^ y);
          tick();
          e_a = s[0] ? W'(y) : W'(x);
          chk("R8 a_out", a_out, e_a);
          chk("R9 b1_out hold", b1_out, 0);
          chk("R9 b2_out hold", b2_out, 0);
        end

    // R2: direction change waits for the edge; load on that edge still B-to-A
    b1_in = 4'd5; b2_in = 4'd9; sel = 1'b0; a_in = 4'd3;
    dir_in = 1'b1; #1;
    chk("R2 a_oe before edge", a_oe, 1);
    chk("R2 b_oe before edge", b_oe, 0);
    tick();
    e_a = 4'd5;
    chk("R2 a_out load on turn edge", a_out, e_a);
    chk("R4 b_oe", b_oe, 1);
    chk("R4 a_oe", a_oe, 0);
    chk("R9 b2_out still held", b2_out, 0);

    // R5 / R6 / R7 / R10: exhaustive A-to-B pairing sweep
    for (int x = 0; x < N; x++)
      for (int y = 0; y < N; y++) begin
        sel = 1'b0; a_in = W'(x); b1_in = W'(y); b2_in = W'(x);
        tick();
        e_stage = W'(x);
        chk("R5 b1_out unchanged", b1_out, e_b1);
        chk("R5 b2_out unchanged", b2_out, e_b2);
        chk("R9 a_out hold", a_out, e_a);
        sel = 1'b1; a_in = W'(y);
        tick();
        e_b1 = e_stage; e_b2 = W'(y);
        chk("R6 b1_out", b1_out, e_b1);
        chk("R7 b2_out pair", b2_out, e_b2);
        if (((x + y) % 5) == 0) begin
          a_in = ~W'(y);
          tick();
          e_b2 = ~W'(y);
          chk("R10 b1_out stays", b1_out, e_b1);
          chk("R6 b2_out follows", b2_out, e_b2);
        end
      end

    // R3 with direction 1
    oe_n = 1'b1; #1;
    chk("R3 b_oe off", b_oe, 0);
    chk("R3 a_oe off", a_oe, 0);
    oe_n = 1'b0;

    // Back to B-to-A: last edge still A-to-B, then A loads and B holds
    sel = 1'b0; a_in = 4'd7; dir_in = 1'b0; b1_in = 4'd12; b2_in = 4'd1;
    tick();
    e_stage = 4'd7;
    chk("R2 a_oe after edge", a_oe, 1);
    chk("R9 a_out held on turn edge", a_out, e_a);
    sel = 1'b1; a_in = 4'd2;
    tick();
    chk("R8 a_out b2", a_out, 1);
    chk("R9 b1_out hold", b1_out, e_b1);
    chk("R9 b2_out hold", b2_out, e_b2);
    // staging register held 7 through B-to-A cycles
    dir_in = 1'b1;
    tick();
    sel = 1'b1; a_in = 4'd11;
    tick();
    chk("R9 stage held then R6 b1_out", b1_out, 7);
    chk("R6 b2_out", b2_out, 11);

    // R1: reset mid-run clears again
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 b1_out after reset", b1_out, 0);
    chk("R1 a_oe after reset", a_oe, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule